// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into one shared level vector and drives two request lines to a processor. One is a normal request and one is a fast request. Each line has its own enable mask. A line rises when any source that its mask enables is active.

Software never needs a read-modify-write to change a mask. Each mask has one word where written ones add enables and another word where written ones remove them. Source 0 can also be raised by software through a latch that is ORed with the external source 0 line. For each line, software can read the masked status and the raw level.

The register bus is word addressed and takes a single-cycle write strobe or read strobe. A read returns its data one cycle after the strobe, qualified by a one-cycle valid pulse. The bus has no back-pressure: every access is accepted in the cycle it is presented, and a response is never held or dropped. The two request lines are plain registered pins.

Top module: `irqc_dual_ctrl`

## Requirements
- R1: After reset both enable masks and the software latch are zero, both request outputs are low and `rd_valid_o` is low.
- R2: Reading word 0 returns level AND normal mask. Reading word 1 returns the raw level. Reading word 2 returns the normal mask. Unused upper bits read as zero.
- R3: Writing word 2 ORs the write data into the normal mask. Writing word 3 clears the normal mask bits that are written as ones and leaves the others unchanged.
- R4: For the fast line, word 8 returns level AND fast mask and word 9 returns the raw level. Word 10 reads the fast mask, and writing it ORs data into that mask. Writing word 11 clears the fast mask bits written as ones.
- R5: Writing word 4 with data bit 0 high sets the software latch. Writing word 5 with data bit 0 high clears it. Either write with bit 0 low has no effect. Level bit 0 is external source 0 OR the latch, and reading word 4 returns level bit 0 in data bit 0.
- R6: `irq_o` equals the OR of (level AND normal mask) as it stood in the previous cycle.
- R7: `fiq_o` equals the OR of (level AND fast mask) as it stood in the previous cycle.
- R8: Reads of words 3, 5, 11 and of any undefined word return zero. Writes to words 0, 1, 8, 9 and to undefined words change no state.
- R9: Each read strobe produces exactly one `rd_valid_o` pulse, in the next cycle, carrying the data for the addressed word. No pulse occurs without a strobe.
- R10: Level bits 1 and up follow their external source inputs directly. Bit 0 follows its input as described in R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Level interrupt inputs |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | AW | Word address |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data, valid with `rd_valid_o` |
| rd_valid_o | output | 1 | One-cycle read response pulse |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions check several properties on every cycle. Each read strobe must be answered by a valid pulse in the next cycle, with no extra pulses. A set write must leave its bits enabled, and a full clear write must empty the mask. A clear write to word 5 must drop the software latch. A request line must stay low in the cycle after its mask was empty.

Other behaviour is shown only by the bench scenarios. These cover the exact read values of each word, and the OR of the software latch with external source 0. They also check that writes to status and undefined words are ignored, and that the request lines follow source changes as masks are added and removed.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int REG_AW = 6;
  // word indices decoded by software drivers
  localparam int W_IRQ_STAT = 0;
  localparam int W_IRQ_RAW  = 1;
  localparam int W_IRQ_SET  = 2;
  localparam int W_IRQ_CLR  = 3;
  localparam int W_SW_SET   = 4;
  localparam int W_SW_CLR   = 5;
  localparam int W_FIQ_STAT = 8;
  localparam int W_FIQ_RAW  = 9;
  localparam int W_FIQ_SET  = 10;
  localparam int W_FIQ_CLR  = 11;
  localparam int NCHAN      = 2;   // 0: normal, 1: fast
endpackage

// File: rtl/irqc_mask_reg.sv
module irqc_mask_reg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits_i,
  output logic [W-1:0] mask_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      mask_q <= '0;
    else if (set_en)
      mask_q <= mask_q | bits_i;
    else if (clr_en)
      mask_q <= mask_q & ~bits_i;
  end
endmodule

// File: rtl/irqc_level.sv
module irqc_level #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            sw_set,
  input  logic            sw_clr,
  output logic            sw_q,
  output logic [NSRC-1:0] level_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      sw_q <= 1'b0;
    else if (sw_set)
      sw_q <= 1'b1;
    else if (sw_clr)
      sw_q <= 1'b0;
  end

  always_comb begin
    level_o    = src_i;
    level_o[0] = src_i[0] | sw_q;
  end
endmodule

// File: rtl/irqc_req_out.sv
module irqc_req_out #(
  parameter int NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] level_i,
  input  logic [NSRC-1:0] mask_i,
  output logic            req_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      req_q <= 1'b0;
    else
      req_q <= |(level_i & mask_i);
  end
endmodule

// File: rtl/irqc_dual_ctrl.sv
module irqc_dual_ctrl #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = irqc_pkg::REG_AW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            rd_valid_o,
  output logic            irq_o,
  output logic            fiq_o
);
  import irqc_pkg::*;

  localparam logic [AW-1:0] A_SET [NCHAN] = '{AW'(W_IRQ_SET), AW'(W_FIQ_SET)};
  localparam logic [AW-1:0] A_CLR [NCHAN] = '{AW'(W_IRQ_CLR), AW'(W_FIQ_CLR)};

  logic [NSRC-1:0] level;
  logic [NSRC-1:0] mask [NCHAN];
  logic [NCHAN-1:0] req;
  logic            sw_q;
  logic [DW-1:0]   rd_mux;

  irqc_level #(.NSRC(NSRC)) u_level (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .sw_set  (wr_en_i && addr_i == AW'(W_SW_SET) && wdata_i[0]),
    .sw_clr  (wr_en_i && addr_i == AW'(W_SW_CLR) && wdata_i[0]),
    .sw_q    (sw_q),
    .level_o (level)
  );

  for (genvar c = 0; c < NCHAN; c++) begin : g_chan
    irqc_mask_reg #(.W(NSRC)) u_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_en (wr_en_i && addr_i == A_SET[c]),
      .clr_en (wr_en_i && addr_i == A_CLR[c]),
      .bits_i (wdata_i[NSRC-1:0]),
      .mask_q (mask[c])
    );
    irqc_req_out #(.NSRC(NSRC)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (level),
      .mask_i  (mask[c]),
      .req_q   (req[c])
    );
  end

  assign irq_o = req[0];
  assign fiq_o = req[1];

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      AW'(W_IRQ_STAT): rd_mux = DW'(level & mask[0]);
      AW'(W_IRQ_RAW),
      AW'(W_FIQ_RAW):  rd_mux = DW'(level);
      AW'(W_IRQ_SET):  rd_mux = DW'(mask[0]);
      AW'(W_SW_SET):   rd_mux = DW'(level[0]);
      AW'(W_FIQ_STAT): rd_mux = DW'(level & mask[1]);
      AW'(W_FIQ_SET):  rd_mux = DW'(mask[1]);
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i)
        rdata_o <= rd_mux;
    end
  end
endmodule

// File: rtl/irqc_dual_ctrl_chk.sv
module irqc_dual_ctrl_chk #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = irqc_pkg::REG_AW
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [DW-1:0]   wdata_i,
  input logic            rd_valid_o,
  input logic            irq_o,
  input logic            fiq_o,
  input logic [NSRC-1:0] irq_mask,
  input logic [NSRC-1:0] fiq_mask,
  input logic            sw_q
);
  import irqc_pkg::*;

  assert_rd_resp_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en_i |=> rd_valid_o);
  assert_no_spurious_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en_i |=> !rd_valid_o);
  assert_irq_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(W_IRQ_SET)) |=>
      ((irq_mask & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));
  assert_irq_clr_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(W_IRQ_CLR) && &wdata_i[NSRC-1:0]) |=> irq_mask == '0);
  assert_fiq_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(W_FIQ_SET)) |=>
      ((fiq_mask & $past(wdata_i[NSRC-1:0])) == $past(wdata_i[NSRC-1:0])));
  assert_sw_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && addr_i == AW'(W_SW_CLR) && wdata_i[0]) |=> !sw_q);
  assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask == '0) |=> !irq_o);
  assert_fiq_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_mask == '0) |=> !fiq_o);
endmodule

bind irqc_dual_ctrl irqc_dual_ctrl_chk #(.NSRC(NSRC), .DW(DW), .AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .addr_i     (addr_i),
  .wdata_i    (wdata_i),
  .rd_valid_o (rd_valid_o),
  .irq_o      (irq_o),
  .fiq_o      (fiq_o),
  .irq_mask   (mask[0]),
  .fiq_mask   (mask[1]),
  .sw_q       (sw_q)
);

// File: tb/tb_irqc_dual_ctrl.sv
`timescale 1ns/1ps
module tb_irqc_dual_ctrl;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NSRC-1:0] src_i = '0;
  logic wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [AW-1:0] addr_i = '0;
  logic [DW-1:0] wdata_i = '0;
  logic [DW-1:0] rdata_o;
  logic rd_valid_o, irq_o, fiq_o;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;

  irqc_dual_ctrl #(.NSRC(NSRC), .DW(DW), .AW(AW)) dut (.*);

  task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; addr_i = AW'(a); wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0; wdata_i = '0;
  endtask

  task automatic bus_rd(input int a, input logic [DW-1:0] exp, input string tag);
    @(negedge clk);
    rd_en_i = 1'b1; addr_i = AW'(a);
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  // monitor: pops the scoreboard on every response
  always @(negedge clk) begin
    if (rst_n && rd_valid_o) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R9: unexpected response actual %h expected none", rdata_o);
      end else begin
        check(tag_q.pop_front(), rdata_o, exp_q.pop_front());
      end
    end
  end

  initial begin
    #(5.0 * 100000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
    check("R1 irq_o", DW'(irq_o), 0);
    check("R1 fiq_o", DW'(fiq_o), 0);
    check("R1 rd_valid", DW'(rd_valid_o), 0);
    bus_rd(2, 0, "R1 irq mask");
    bus_rd(10, 0, "R1 fiq mask");
    bus_rd(4, 0, "R1 soft latch");
    settle();
    check("R9 single pulse", DW'(rd_valid_o), 0);

    // raw levels
    @(negedge clk); src_i = 32'h0000_0F00;
    bus_rd(1, 32'h0000_0F00, "R10 raw irq view");
    bus_rd(9, 32'h0000_0F00, "R4 raw fiq view");
    bus_rd(0, 0, "R2 masked empty");

    // normal mask set/clear
    bus_wr(2, 32'h0000_0300);
    bus_rd(2, 32'h0000_0300, "R3 set");
    check("R6 irq high", DW'(irq_o), 1);
    check("R7 fiq low", DW'(fiq_o), 0);
    bus_rd(0, 32'h0000_0300, "R2 masked");
    bus_wr(2, 32'h8000_0001);
    bus_rd(2, 32'h8000_0301, "R3 or");
    bus_wr(3, 32'h0000_0301);
    settle();
    check("R6 irq low after clear", DW'(irq_o), 0);
    bus_rd(2, 32'h8000_0000, "R3 clear");
    @(negedge clk); src_i[31] = 1'b1;
    settle();
    check("R6 irq follows source", DW'(irq_o), 1);
    @(negedge clk); src_i[31] = 1'b0;
    settle();
    check("R6 irq drops with source", DW'(irq_o), 0);

    // fast mask
    bus_wr(10, 32'h0000_0C00);
    bus_rd(10, 32'h0000_0C00, "R4 fiq set");
    check("R7 fiq high", DW'(fiq_o), 1);
    bus_rd(8, 32'h0000_0C00, "R4 fiq masked");
    bus_wr(11, 32'hFFFF_FFFF);
    settle();
    check("R7 fiq low", DW'(fiq_o), 0);
    bus_rd(10, 0, "R4 fiq clear");

    // software source 0
    @(negedge clk); src_i = '0;
    bus_wr(4, 32'h0000_0002);
    bus_rd(4, 0, "R5 set bit0 low ignored");
    bus_wr(4, 32'h0000_0001);
    bus_rd(4, 1, "R5 soft set");
    bus_rd(1, 1, "R5 raw bit0");
    bus_wr(2, 32'h0000_0001);
    settle();
    check("R6 irq from soft source", DW'(irq_o), 1);
    bus_wr(5, 32'h0000_0002);
    bus_rd(4, 1, "R5 clr bit0 low ignored");
    bus_wr(5, 32'h0000_0001);
    bus_rd(4, 0, "R5 soft clear");
    check("R6 irq after soft clear", DW'(irq_o), 0);
    @(negedge clk); src_i[0] = 1'b1;
    bus_wr(4, 32'h0000_0001);
    bus_wr(5, 32'h0000_0001);
    bus_rd(4, 1, "R5 external keeps bit0");
    @(negedge clk); src_i[0] = 1'b0;
    bus_rd(4, 0, "R5 bit0 drops");

    // ignored writes and zero reads
    bus_wr(0, 32'hFFFF_FFFF);
    bus_wr(1, 32'hFFFF_FFFF);
    bus_wr(8, 32'hFFFF_FFFF);
    bus_wr(9, 32'hFFFF_FFFF);
    bus_wr(20, 32'hFFFF_FFFF);
    bus_rd(2, 32'h8000_0001, "R8 irq mask untouched");
    bus_rd(10, 0, "R8 fiq mask untouched");
    bus_rd(4, 0, "R8 latch untouched");
    bus_rd(3, 0, "R8 read clr word");
    bus_rd(5, 0, "R8 read soft clr word");
    bus_rd(11, 0, "R8 read fiq clr word");
    bus_rd(7, 0, "R8 read undefined");
    bus_rd(63, 0, "R8 read top undefined");
    repeat (3) settle();
    check("R9 all responses seen", DW'(exp_q.size()), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule